// File: doc/BRIEF.md
# Reloading Down Counter with Count Capture

This block is an 8-bit programmable down counter driven by a small register interface. A data input serves as the count enable. While the block is switched on and the enable is high, the counter steps down by one on each clock. When it reaches zero it reloads from a period register. The zero state is flagged on a terminal-count output, and one cycle later a single-cycle interrupt pulse follows. A compare output is high while the live count is at or below a programmable compare value.

Software reads the live count in two steps. A read of the counter register returns the count and also copies it into the compare/capture register, which replaces any compare value written earlier. A later read of that register returns the snapshot. While the block is switched off, its clock enable is low, the count is frozen and all three outputs are held low. A period write in this state also loads the counter directly. If the enable falls in the same cycle as terminal count, one more step still happens: the counter reloads from the period register and then stops.

Top module: `reload_down_counter`

## Requirements
- R1: After reset the period, counter, compare and control registers read 0, and `tc_o`, `cmp_o` and `irq_o` are low.
- R2: With control bit 0 set and `cnt_en_i` high, each clock lowers the count by one. A count of zero reloads the period value on the next clock. `tc_o` is high during the cycle in which the count is zero and `cnt_en_i` is high.
- R3: `irq_o` is a one-cycle pulse in the cycle after `tc_o` was high.
- R4: With the block on and `cnt_en_i` low, a nonzero count holds its value.
- R5: If `cnt_en_i` falls while the count is zero, the next clock reloads the period value (without a terminal-count flag), and the count then holds.
- R6: With control bit 0 (address 3) clear, the count is frozen regardless of `cnt_en_i`, and `tc_o`, `cmp_o` and `irq_o` are low.
- R7: While the block is off, a write to the period register (address 1) also loads the counter register (address 0) with the written value.
- R8: While the block is on, a period write leaves the running count unchanged, and the new value is used at the next reload.
- R9: A read at address 0 returns the live count on `bus_rdata_o` one cycle later and copies that count into the compare register (address 2), which replaces its previous content.
- R10: The compare register at address 2 can be written and read back, and `cmp_o` is high while the block is on and count <= compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Count enable data input |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register select: 0 counter, 1 period, 2 compare/capture, 3 control |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| tc_o | output | 1 | Terminal-count flag |
| cmp_o | output | 1 | Count at or below compare value |
| irq_o | output | 1 | Interrupt pulse following terminal count |

## Verification
A register write or a count step shows at the ports after one rising edge, and read data appears one edge after the read strobe. `tc_o` follows the count and the enable input in the same cycle, and `irq_o` rises one edge after it. The bench drives all stimulus on the falling edge and samples on a later falling edge. It counts exactly the rising edges each result needs, for example five edges from a count of five down to zero, then one more edge for the reload and the interrupt. The count is observed through reads at address 0, so every check of the count sees the value that was held between edges.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_COUNT  = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_CMP    = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rdc_rst_sync.sv
module rdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  timeunit 1ns; timeprecision 1ps;

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rdc_regs.sv
module rdc_regs
  import rdc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    count_i,
  output logic [DW-1:0]    rdata_o,
  output logic [DW-1:0]    period_o,
  output logic [DW-1:0]    cmp_val_o,
  output logic             run_o,
  output logic             load_o
);
  timeunit 1ns; timeprecision 1ps;

  reg_sel_e sel;
  logic [DW-1:0] period_q, period_d;
  logic [DW-1:0] cmp_q, cmp_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          run_q, run_d;
  logic [DW-1:0] rd_mux;

  assign sel = reg_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      SEL_COUNT:  rd_mux = count_i;
      SEL_PERIOD: rd_mux = period_q;
      SEL_CMP:    rd_mux = cmp_q;
      default:    rd_mux = {{(DW-1){1'b0}}, run_q};
    endcase
  end

  always_comb begin
    period_d = period_q;
    cmp_d    = cmp_q;
    run_d    = run_q;
    rdata_d  = rdata_q;
    if (wr_i) begin
      unique case (sel)
        SEL_PERIOD: period_d = wdata_i;
        SEL_CMP:    cmp_d    = wdata_i;
        SEL_CTRL:   run_d    = wdata_i[0];
        default:    ;
      endcase
    end
    if (rd_i) begin
      rdata_d = rd_mux;
      if (sel == SEL_COUNT && !wr_i) cmp_d = count_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cmp_q    <= '0;
      run_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_i)         period_q <= period_d;
      if (wr_i || rd_i) cmp_q    <= cmp_d;
      if (wr_i)         run_q    <= run_d;
      if (rd_i)         rdata_q  <= rdata_d;
    end
  end

  assign rdata_o   = rdata_q;
  assign period_o  = period_q;
  assign cmp_val_o = cmp_q;
  assign run_o     = run_q;
  assign load_o    = wr_i && (sel == SEL_PERIOD) && !run_q;

  AST_CAPTURE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && sel == SEL_COUNT) |=> (cmp_q == $past(count_i))); // R9
  AST_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && sel == SEL_COUNT) |=> (rdata_o == $past(count_i))); // R9
endmodule

// File: rtl/rdc_core.sv
module rdc_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          cnt_en_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic [DW-1:0] period_i,
  input  logic [DW-1:0] cmp_val_i,
  output logic [DW-1:0] count_o,
  output logic          tc_o,
  output logic          cmp_o,
  output logic          irq_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [DW-1:0] cnt_q, cnt_d;
  logic          en_q;
  logic          irq_q;
  logic          zero, step, cnt_ce, tc;

  assign zero   = (cnt_q == '0);
  assign step   = run_i && (cnt_en_i || (en_q && zero));
  assign cnt_ce = load_i || step;
  assign tc     = run_i && cnt_en_i && zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)    cnt_d = load_val_i;
    else if (step) cnt_d = zero ? period_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      en_q  <= cnt_en_i && run_i;
      irq_q <= tc;
    end
  end

  assign count_o = cnt_q;
  assign tc_o    = tc;
  assign cmp_o   = run_i && (cnt_q <= cmp_val_i);
  assign irq_o   = irq_q && run_i;

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && cnt_en_i && cnt_q != '0) |=> (cnt_q == DW'($past(cnt_q) - 1'b1))); // R2
  AST_TC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |=> (cnt_q == $past(period_i))); // R2
  AST_IRQ_AFTER_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o && run_i) |=> (irq_o || !run_i)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !cnt_en_i && cnt_q != '0) |=> $stable(cnt_q)); // R4
  AST_EXTRA_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && $fell(cnt_en_i) && cnt_q == '0) |=> (cnt_q == $past(period_i))); // R5
  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(cnt_q)); // R6
  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i))); // R7
endmodule

// File: rtl/reload_down_counter.sv
module reload_down_counter
  import rdc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [SEL_W-1:0] bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             tc_o,
  output logic             cmp_o,
  output logic             irq_o
);
  timeunit 1ns; timeprecision 1ps;

  logic          rst_sync_n;
  logic [DW-1:0] count, period, cmp_val;
  logic          run, load;

  rdc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rdc_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_i      (bus_wr_i),
    .rd_i      (bus_rd_i),
    .sel_i     (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .count_i   (count),
    .rdata_o   (bus_rdata_o),
    .period_o  (period),
    .cmp_val_o (cmp_val),
    .run_o     (run),
    .load_o    (load)
  );

  rdc_core #(.DW(DW)) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run_i      (run),
    .cnt_en_i   (cnt_en_i),
    .load_i     (load),
    .load_val_i (bus_wdata_i),
    .period_i   (period),
    .cmp_val_i  (cmp_val),
    .count_o    (count),
    .tc_o       (tc_o),
    .cmp_o      (cmp_o),
    .irq_o      (irq_o)
  );

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run |-> (!tc_o && !cmp_o && !irq_o)); // R6
  AST_RUN_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && bus_wr_i && bus_addr_i == SEL_PERIOD && !cnt_en_i && count != '0) |=> $stable(count)); // R8
endmodule

// File: tb/reload_down_counter_tb.sv
module reload_down_counter_tb;
  timeunit 1ns; timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_en;
  logic       wr, rd;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       tc, cmpo, irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  reload_down_counter u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en_i    (cnt_en),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .tc_o        (tc),
    .cmp_o       (cmpo),
    .irq_o       (irq)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 tc after reset", tc, 0);
    chk("R1 cmp after reset", cmpo, 0);
    chk("R1 irq after reset", irq, 0);
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), v);
      chk("R1 register reads 0", v, 0);
    end
  endtask

  task automatic t_off_load;
    logic [7:0] v;
    bus_write(2'd1, 8'd5);
    bus_read(2'd0, v);
    chk("R7 period write loads counter while off", v, 5);
    bus_write(2'd2, 8'd9);
    cnt_en = 1'b1;
    cyc(3);
    chk("R6 tc low while off", tc, 0);
    chk("R6 cmp low while off", cmpo, 0);
    chk("R6 irq low while off", irq, 0);
    cnt_en = 1'b0;
    bus_read(2'd0, v);
    chk("R6 count frozen while off", v, 5);
  endtask

  task automatic t_countdown;
    logic [7:0] v;
    bus_write(2'd3, 8'd1);
    chk("R10 cmp high with count<=compare", cmpo, 1);
    cnt_en = 1'b1;
    cyc(5);
    chk("R2 tc at zero", tc, 1);
    chk("R3 irq not yet", irq, 0);
    cyc(1);
    chk("R2 tc drops after reload", tc, 0);
    chk("R3 irq pulse", irq, 1);
    cyc(1);
    chk("R3 irq single cycle", irq, 0);
    cnt_en = 1'b0;
    cyc(3);
    bus_read(2'd0, v);
    chk("R4 hold with enable low", v, 4);
  endtask

  task automatic t_period_running;
    logic [7:0] v;
    bus_write(2'd1, 8'd7);
    bus_read(2'd0, v);
    chk("R8 running count undisturbed by period write", v, 4);
    cnt_en = 1'b1;
    cyc(4);
    chk("R2 tc after four steps", tc, 1);
    cyc(1);
    cnt_en = 1'b0;
    cyc(1);
    bus_read(2'd0, v);
    chk("R8 new period used at reload", v, 7);
  endtask

  task automatic t_extra;
    logic [7:0] v;
    bus_write(2'd1, 8'd3);
    cnt_en = 1'b1;
    cyc(7);
    chk("R5 count reached zero", tc, 1);
    cnt_en = 1'b0;
    cyc(1);
    chk("R5 no tc on extra step", tc, 0);
    chk("R5 no irq on extra step", irq, 0);
    cyc(3);
    bus_read(2'd0, v);
    chk("R5 extra step reloads period then stops", v, 3);
  endtask

  task automatic t_capture;
    logic [7:0] v;
    bus_write(2'd2, 8'h40);
    bus_read(2'd2, v);
    chk("R10 compare read back", v, 8'h40);
    chk("R10 cmp high count 3 <= 0x40", cmpo, 1);
    bus_write(2'd2, 8'd1);
    chk("R10 cmp low count 3 > 1", cmpo, 0);
    bus_read(2'd0, v);
    chk("R9 read returns live count", v, 3);
    bus_read(2'd2, v);
    chk("R9 capture overwrote compare", v, 3);
    chk("R9 cmp follows captured value", cmpo, 1);
  endtask

  task automatic t_off_keep;
    logic [7:0] v;
    bus_write(2'd3, 8'd0);
    bus_read(2'd0, v);
    chk("R6 disabling keeps count", v, 3);
    chk("R6 cmp low after disable", cmpo, 0);
    cnt_en = 1'b1;
    cyc(3);
    chk("R6 tc low with enable high while off", tc, 0);
    bus_read(2'd0, v);
    chk("R6 count frozen with enable high", v, 3);
    cnt_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_off_load();
    t_countdown();
    t_period_running();
    t_extra();
    t_capture();
    t_off_keep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule